// File: doc/BRIEF.md
# Hot-Swap Insertion Power Sequencer

This controller governs power-up of a plug-in board. Two active-low connection-sense inputs show that the board is seated. The controller starts the gate ramp only after both pins have been held low for a qualifying time and the supply is above its undervoltage-lockout level. All timing is counted in ticks of a one-millisecond strobe `ms_tick`. Comparator results, such as the lockout status and the output-discharged status, arrive as synchronous digital flags.

A bus-isolation output stays high from power-on until the board is fully powered. The data bus is therefore kept apart during insertion, qualification and ramping. An active-low hard-reset request turns the pump off and drives the output discharge. Once the request has gone away and the output rail is reported as discharged, the controller returns to idle and a fresh insertion sequence can run. Losing a sense pin or the supply while powered drops the gate enable at once and returns the controller to waiting.

Top module: `hsw_seq`

## Requirements
- R1: During and right after reset the state is idle (`state_oh` = 5'b00001), `bus_iso` is 1, and `pump_en` and `discharge_en` are 0.
- R2: Qualification counts `ms_tick` strobes while both sense pins stay low. The first strobe counted is the one after the cycle that entered qualification. Power-up can start only once more than QUAL_MS strobes have been counted.
- R3: If either sense pin goes high during qualification, the state returns to idle on the next edge and the count starts again from zero.
- R4: After qualification completes, the state stays in qualification while `uvlo_ok` is 0. The ramp starts on the first edge where `uvlo_ok` is 1.
- R5: In the ramp state (5'b00100) `pump_en` is 1. The ramp ends after RAMP_MS strobes, and the state becomes on (5'b01000). `pump_en` stays 1 in the on state, and `bus_iso` is 0 only in the on state.
- R6: A 0 on `por_n` at a clock edge puts the state into discharge (5'b10000), whatever the current state. In discharge `pump_en` is 0 and `discharge_en` is 1, and the state holds there while `por_n` stays 0.
- R7: In the ramp or on state, with `por_n` at 1, a high sense pin or `uvlo_ok` at 0 returns the state to idle on the next edge, with `pump_en` at 0.
- R8: The discharge state leaves for idle only on an edge where `por_n` is 1 and `out_discharged` is 1.
- R9: `state_oh` is one-hot with the bits idle=0, qualify=1, ramp=2, on=3, discharge=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ms_tick | input | 1 | one-cycle strobe per millisecond |
| sense_a_n | input | 1 | first connection-sense pin, low when seated |
| sense_b_n | input | 1 | second connection-sense pin, low when seated |
| uvlo_ok | input | 1 | supply above the lockout threshold |
| por_n | input | 1 | hard-reset request, active low |
| out_discharged | input | 1 | low output rail is near ground |
| pump_en | output | 1 | charge-pump and gate-ramp enable |
| discharge_en | output | 1 | active output pull-down |
| bus_iso | output | 1 | data-bus isolation, high to isolate |
| state_oh | output | 5 | one-hot state |

## Verification
The assertions check on every cycle:
- the one-hot state encoding;
- that a hard-reset request forces discharge with the pump off;
- that loss of a pin or of the supply drops power on the next edge;
- that the discharge exit waits for the discharged flag;
- that every rising edge of the pump enable follows an unbroken low on both pins lasting longer than the qualifying time.

Only the bench's scenarios show the exact tick at which qualification and the ramp end, the restart of the count after a glitch, and the hold in qualification while the supply is low.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic [4:0] {
    ST_IDLE = 5'b00001,
    ST_QUAL = 5'b00010,
    ST_RAMP = 5'b00100,
    ST_ON   = 5'b01000,
    ST_DIS  = 5'b10000
  } hsw_state_t;

  // strictly longer than the limit
  function automatic logic window_elapsed(input int unsigned cnt, input int unsigned lim);
    return cnt > lim;
  endfunction

  // at least the limit
  function automatic logic limit_reached(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/hsw_tick_cnt.sv
module hsw_tick_cnt #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned MAX   = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && cnt != CAP)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hsw_ctrl_fsm.sv
module hsw_ctrl_fsm
  import hsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       present,
  input  logic       uvlo_ok,
  input  logic       por_n,
  input  logic       out_discharged,
  input  logic       qual_done,
  input  logic       ramp_done,
  output hsw_state_t state,
  output logic       state_change
);
  hsw_state_t nxt;

  always_comb begin
    nxt = state;
    if (!por_n) begin
      nxt = ST_DIS;
    end else begin
      unique case (state)
        ST_IDLE: if (present) nxt = ST_QUAL;
        ST_QUAL: begin
          if (!present)                  nxt = ST_IDLE;
          else if (qual_done && uvlo_ok) nxt = ST_RAMP;
        end
        ST_RAMP: begin
          if (!present || !uvlo_ok) nxt = ST_IDLE;
          else if (ramp_done)       nxt = ST_ON;
        end
        ST_ON:   if (!present || !uvlo_ok) nxt = ST_IDLE;
        ST_DIS:  if (out_discharged) nxt = ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign state_change = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/hsw_out_dec.sv
module hsw_out_dec
  import hsw_pkg::*;
(
  input  hsw_state_t state,
  output logic       pump_en,
  output logic       discharge_en,
  output logic       bus_iso,
  output logic [4:0] state_oh
);
  always_comb begin
    pump_en      = (state == ST_RAMP) || (state == ST_ON);
    discharge_en = (state == ST_DIS);
    bus_iso      = (state != ST_ON);
    state_oh     = state;
  end
endmodule

// File: rtl/hsw_seq.sv
module hsw_seq
  import hsw_pkg::*;
#(
  parameter int unsigned QUAL_MS = 20,
  parameter int unsigned RAMP_MS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       sense_a_n,
  input  logic       sense_b_n,
  input  logic       uvlo_ok,
  input  logic       por_n,
  input  logic       out_discharged,
  output logic       pump_en,
  output logic       discharge_en,
  output logic       bus_iso,
  output logic [4:0] state_oh
);
  localparam int unsigned CNT_MAX = (QUAL_MS + 1 > RAMP_MS) ? QUAL_MS + 1 : RAMP_MS;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  // named internal events
  logic             present;
  logic             qual_done;
  logic             ramp_done;
  logic             state_change;
  logic [CNT_W-1:0] cnt;
  hsw_state_t       state;

  assign present   = !sense_a_n && !sense_b_n;
  assign qual_done = window_elapsed(32'(cnt), QUAL_MS);
  assign ramp_done = limit_reached(32'(cnt), RAMP_MS);

  hsw_tick_cnt #(.CNT_W(CNT_W), .MAX(CNT_MAX)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(state_change), .inc(ms_tick), .cnt(cnt)
  );

  hsw_ctrl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .present(present), .uvlo_ok(uvlo_ok),
    .por_n(por_n), .out_discharged(out_discharged), .qual_done(qual_done),
    .ramp_done(ramp_done), .state(state), .state_change(state_change)
  );

  hsw_out_dec u_dec (
    .state(state), .pump_en(pump_en), .discharge_en(discharge_en),
    .bus_iso(bus_iso), .state_oh(state_oh)
  );
endmodule

// File: rtl/hsw_seq_chk.sv
module hsw_seq_chk #(
  parameter int unsigned QUAL_MS = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic       sense_a_n,
  input logic       sense_b_n,
  input logic       uvlo_ok,
  input logic       por_n,
  input logic       out_discharged,
  input logic       pump_en,
  input logic       discharge_en,
  input logic       bus_iso,
  input logic [4:0] state_oh
);
  // ticks seen while both pins stay low, saturating
  int unsigned hold_ticks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                hold_ticks <= 0;
    else if (sense_a_n || sense_b_n)           hold_ticks <= 0;
    else if (ms_tick && hold_ticks <= QUAL_MS) hold_ticks <= hold_ticks + 1;
  end

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1);

  p_por_discharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !por_n |=> (state_oh[4] && discharge_en && !pump_en));

  p_iso_only_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_iso |-> (pump_en && state_oh[3]));

  p_loss_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (por_n && (state_oh[2] || state_oh[3]) && (sense_a_n || sense_b_n || !uvlo_ok))
      |=> (state_oh[0] && !pump_en));

  p_dis_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_oh[4] && !(por_n && out_discharged)) |=> state_oh[4]);

  p_dis_leave_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_oh[4] && por_n && out_discharged) |=> state_oh[0]);

  p_qual_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_en) |-> (hold_ticks > QUAL_MS && $past(uvlo_ok)));
endmodule

bind hsw_seq hsw_seq_chk #(.QUAL_MS(QUAL_MS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sense_a_n(sense_a_n),
  .sense_b_n(sense_b_n), .uvlo_ok(uvlo_ok), .por_n(por_n),
  .out_discharged(out_discharged), .pump_en(pump_en),
  .discharge_en(discharge_en), .bus_iso(bus_iso), .state_oh(state_oh)
);

// File: tb/sim_hsw_seq.sv
module sim_hsw_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 32;
  // {sense_a_n, sense_b_n, uvlo_ok, por_n, out_discharged, ms_tick, expected state_oh}
  localparam logic [10:0] VEC [0:NV-1] = '{
    11'b111101_00001, // 0  pins open: idle
    11'b011101_00001, // 1  R2 one pin only: idle
    11'b001101_00010, // 2  both low: qualify
    11'b001101_00010, // 3
    11'b011100_00001, // 4  R3 glitch: idle
    11'b001101_00010, // 5  qualify, count 0
    11'b001101_00010, // 6  count 1
    11'b001101_00010, // 7  count 2
    11'b001101_00010, // 8  count 3 (decision saw 2)
    11'b000100_00010, // 9  R4 supply low: hold
    11'b001100_00100, // 10 ramp
    11'b001101_00100, // 11 count 1
    11'b001100_00100, // 12
    11'b001101_00100, // 13 count 2
    11'b001100_01000, // 14 R5 on
    11'b001101_01000, // 15
    11'b000100_00001, // 16 R7 supply lost
    11'b001100_00010, // 17
    11'b001101_00010, // 18
    11'b001101_00010, // 19
    11'b001101_00010, // 20
    11'b001100_00100, // 21
    11'b001101_00100, // 22
    11'b001101_00100, // 23
    11'b001100_01000, // 24
    11'b011100_00001, // 25 R7 pin lost
    11'b001100_00010, // 26
    11'b001000_10000, // 27 R6 por
    11'b001010_10000, // 28 R8 por still low
    11'b001100_10000, // 29 R8 not discharged
    11'b001110_00001, // 30 R8 exit
    11'b001100_00010  // 31
  };

  logic clk = 0, rst_n = 0, ms_tick = 0, sense_a_n = 1, sense_b_n = 1;
  logic uvlo_ok = 1, por_n = 1, out_discharged = 0;
  logic pump_en, discharge_en, bus_iso;
  logic [4:0] state_oh;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsw_seq #(.QUAL_MS(2), .RAMP_MS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sense_a_n(sense_a_n),
    .sense_b_n(sense_b_n), .uvlo_ok(uvlo_ok), .por_n(por_n),
    .out_discharged(out_discharged), .pump_en(pump_en),
    .discharge_en(discharge_en), .bus_iso(bus_iso), .state_oh(state_oh)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] v);
    @(negedge clk);
    {sense_a_n, sense_b_n, uvlo_ok, por_n, out_discharged, ms_tick} = v;
    @(posedge clk);
    #(CLK_PERIOD/5);
  endtask

  task automatic chk_state(input logic [4:0] e);
    chk("R9 state", 32'(state_oh), 32'(e));
    chk("R5 pump", 32'(pump_en), 32'(e[2] | e[3]));
    chk("R5 iso", 32'(bus_iso), 32'(!e[3]));
    chk("R6 discharge", 32'(discharge_en), 32'(e[4]));
  endtask

  initial begin
    @(posedge clk); #(CLK_PERIOD/5);
    // R1 reset values
    chk("R1 state", 32'(state_oh), 32'h01);
    chk("R1 iso", 32'(bus_iso), 32'h1);
    chk("R1 pump", 32'(pump_en), 32'h0);
    chk("R1 discharge", 32'(discharge_en), 32'h0);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][10:5]);
      chk_state(VEC[i][4:0]);
    end

    // R6 por during ramp (state is qualify, count 0)
    step(6'b001101); step(6'b001101); step(6'b001101);
    step(6'b001100); chk_state(5'b00100);
    step(6'b001000); chk_state(5'b10000);
    step(6'b001110); chk_state(5'b00001);
    // R7 pin lost during ramp
    step(6'b001100); step(6'b001101); step(6'b001101); step(6'b001101);
    step(6'b001100); chk_state(5'b00100);
    step(6'b101100); chk_state(5'b00001);
    // R1 reset from on
    step(6'b001100); step(6'b001101); step(6'b001101); step(6'b001101);
    step(6'b001100); step(6'b001101); step(6'b001101);
    step(6'b001100); chk_state(5'b01000);
    @(negedge clk) rst_n = 0;
    #(CLK_PERIOD/5);
    chk("R1 state after reset", 32'(state_oh), 32'h01);
    chk("R1 iso after reset", 32'(bus_iso), 32'h1);
    @(negedge clk) rst_n = 1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule